// File: doc/BRIEF.md
# Banked Priority Mask Register

This block holds the priority threshold of one CPU interface. A pending interrupt is forwarded only when its priority value is numerically below the stored threshold, where a smaller value means a more urgent interrupt. The threshold is reached over a small register bus. Each access carries a flag that says whether the requester is in the secure or the non-secure world. When the system has the top exception level and routes Group 0 interrupts to it, non-secure software may only see and change the lower-urgency half of the priority space. It works through a translated view: values shift by one bit, and the top bit is forced on writes.

A second read-only register returns the running priority, which an external active-priority tracker supplies. Reads of it go through the same translated view. Read data is registered and appears one cycle after the read strobe.

Top module: `prio_mask_bank`

## Requirements
- R1: After reset the stored mask is 0x00. With that mask no candidate priority passes, and `bus_rvalid` is low.
- R2: A direct access stores `bus_wdata` unchanged on a write to the mask (`bus_sel`=0). A direct read returns the stored mask unchanged. An access is direct when it is secure, or when the translation condition of R6 is false.
- R3: A translated read of the mask returns the stored value shifted left by one and cut to 8 bits when its bit 7 is 1. When bit 7 is 0 it returns 0x00. So 0xFF reads as 0xFE and 0x7F reads as 0x00.
- R4: A translated write to the mask is ignored when bit 7 of the stored mask is 0.
- R5: A translated write that is accepted stores the written value shifted right by one, with bit 7 set to 1. So 0x64 is stored as 0xB2 and reads back through the translated view as 0x64.
- R6: Translation applies only when `top_el_present`=1, `bus_secure`=0 and `grp0_route_top`=1 all hold. If any one of them fails, the access is direct.
- R7: A read with `bus_sel`=1 returns `run_prio`, under the same translation rule as the mask. A translated 0xFF reads as 0xFE and a translated 0x40 reads as 0x00.
- R8: A write with `bus_sel`=1 has no effect on the stored mask.
- R9: `cand_pass` is 1 in the same cycle exactly when `cand_prio` is strictly less than the stored mask.
- R10: `bus_rvalid` is 1 in exactly the cycle after a cycle with `bus_rd`=1, and `bus_rdata` is valid in that cycle.
- R11: When a read and a write of the mask occur in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | 0 selects the mask, 1 selects the running priority |
| bus_secure | input | 1 | 1 when the access comes from the secure world |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| top_el_present | input | 1 | The highest exception level is implemented |
| grp0_route_top | input | 1 | Group 0 interrupts are routed to the highest level |
| run_prio | input | 8 | Running priority from the active-priority tracker, 0xFF when idle |
| cand_prio | input | 8 | Priority of the candidate pending interrupt |
| cand_pass | output | 1 | Candidate is below the mask |

## Verification
Stored masks are chosen so that bit 7 is set in some and clear in others: 0xFF, 0x7F, 0x80, 0xC3 and 0x40. These values show whether a translated read shifts the value, zeroes it, or passes it through. Translated writes are tried with bit 7 of the stored mask clear and with it set, which separates a blocked write from an accepted one. Each of the three translation conditions is falsified on its own, so a gate that omits one of them shows up. Candidate priorities one below, equal to and above the mask expose an off-by-one or a reversed comparison.

// File: rtl/prio_mask_pkg.sv
package prio_mask_pkg;

    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] MASK_RESET = '0;

    typedef enum logic [0:0] {
        SEL_MASK    = 1'b0,
        SEL_RUNNING = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic             secure;
        logic [PRIO_W-1:0] wdata;
    } bus_req_t;

    function automatic logic xlate_active(input logic top_el, input logic secure,
                                          input logic grp0_top);
        return top_el & ~secure & grp0_top;
    endfunction

endpackage

// File: rtl/pm_view.sv
module pm_view #(
    parameter int PW = 8
) (
    input  logic          xlate,
    input  logic [PW-1:0] raw,
    output logic [PW-1:0] seen
);
    always_comb begin
        if (!xlate) begin
            seen = raw;
        end else if (raw[PW-1]) begin
            seen = {raw[PW-2:0], 1'b0};
        end else begin
            seen = '0;
        end
    end
endmodule

// File: rtl/pm_store.sv
module pm_store #(
    parameter int            PW        = 8,
    parameter logic [PW-1:0] RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          xlate,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] mask_q
);
    logic          accept;
    logic [PW-1:0] next_val;

    always_comb begin
        accept   = wr_en & (~xlate | mask_q[PW-1]);
        next_val = xlate ? {1'b1, wdata[PW-1:1]} : wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= RESET_VAL;
        end else if (accept) begin
            mask_q <= next_val;
        end
    end
endmodule

// File: rtl/pm_gate.sv
module pm_gate #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] cand,
    input  logic [PW-1:0] mask,
    output logic          pass
);
    always_comb pass = (cand < mask);
endmodule

// File: rtl/prio_mask_bank.sv
module prio_mask_bank
    import prio_mask_pkg::*;
#(
    parameter int PW = PRIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_sel,
    input  logic          bus_secure,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    output logic          bus_rvalid,
    input  logic          top_el_present,
    input  logic          grp0_route_top,
    input  logic [PW-1:0] run_prio,
    input  logic [PW-1:0] cand_prio,
    output logic          cand_pass
);
    localparam int NVIEW = 2;

    bus_req_t      req;
    logic          xlate;
    logic [PW-1:0] mask_q;
    logic [PW-1:0] raw_src  [NVIEW];
    logic [PW-1:0] seen_src [NVIEW];

    always_comb begin
        req.wr     = bus_wr;
        req.rd     = bus_rd;
        req.sel    = reg_sel_e'(bus_sel);
        req.secure = bus_secure;
        req.wdata  = bus_wdata[PRIO_W-1:0];
        xlate      = xlate_active(top_el_present, req.secure, grp0_route_top);
        raw_src[0] = mask_q;
        raw_src[1] = run_prio;
    end

    pm_store #(.PW(PW), .RESET_VAL(PW'(MASK_RESET))) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req.wr && req.sel == SEL_MASK),
        .xlate  (xlate),
        .wdata  (bus_wdata),
        .mask_q (mask_q)
    );

    for (genvar v = 0; v < NVIEW; v++) begin : g_view
        pm_view #(.PW(PW)) u_view (
            .xlate (xlate),
            .raw   (raw_src[v]),
            .seen  (seen_src[v])
        );
    end

    pm_gate #(.PW(PW)) u_gate (
        .cand (cand_prio),
        .mask (mask_q),
        .pass (cand_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= req.rd;
            if (req.rd) begin
                bus_rdata <= (req.sel == SEL_RUNNING) ? seen_src[1] : seen_src[0];
            end
        end
    end
endmodule

// File: rtl/prio_mask_chk.sv
module prio_mask_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          bus_sel,
    input logic          bus_secure,
    input logic          top_el_present,
    input logic          grp0_route_top,
    input logic [PW-1:0] bus_rdata,
    input logic          bus_rvalid,
    input logic [PW-1:0] cand_prio,
    input logic          cand_pass,
    input logic [PW-1:0] mask_q
);
    logic ns_view;
    always_comb ns_view = top_el_present & ~bus_secure & grp0_route_top;

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid); // R10
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid); // R10
    AST_NS_READ_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ns_view && !bus_sel && !mask_q[PW-1]) |=> (bus_rdata == '0)); // R3
    AST_NS_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ns_view && !bus_sel && !mask_q[PW-1]) |=> $stable(mask_q)); // R4
    AST_NS_WRITE_KEEPS_MSB: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ns_view && !bus_sel && mask_q[PW-1]) |=> mask_q[PW-1]); // R5
    AST_RUNNING_WRITE_NOP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel) |=> $stable(mask_q)); // R8
    AST_EQUAL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cand_prio == mask_q) |-> !cand_pass); // R9
endmodule

bind prio_mask_bank prio_mask_chk #(.PW(PW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_sel        (bus_sel),
    .bus_secure     (bus_secure),
    .top_el_present (top_el_present),
    .grp0_route_top (grp0_route_top),
    .bus_rdata      (bus_rdata),
    .bus_rvalid     (bus_rvalid),
    .cand_prio      (cand_prio),
    .cand_pass      (cand_pass),
    .mask_q         (mask_q)
);

// File: tb/prio_mask_bank_test.sv
`timescale 1ns/1ps
module prio_mask_bank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0, bus_secure = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic       top_el_present = 1'b1, grp0_route_top = 1'b1;
    logic [7:0] run_prio = 8'hFF, cand_prio = 8'h00;
    logic       cand_pass;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    prio_mask_bank uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_secure(bus_secure), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .top_el_present(top_el_present),
        .grp0_route_top(grp0_route_top), .run_prio(run_prio),
        .cand_prio(cand_prio), .cand_pass(cand_pass)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic sec, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_secure = sec; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic sel, input logic sec, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = sel; bus_secure = sec;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 rvalid after reset", int'(bus_rvalid), 0);
        cand_prio = 8'h00; #1;
        check("R1 no pass at reset", int'(cand_pass), 0);
        do_read(1'b0, 1'b1, d);
        check("R1 reset mask", d, 8'h00);
    endtask

    task automatic t_direct();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'h5A);
        do_read(1'b0, 1'b1, d);
        check("R2 secure readback", d, 8'h5A);
    endtask

    task automatic t_ns_read();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'hFF); do_read(1'b0, 1'b0, d);
        check("R3 0xFF view", d, 8'hFE);
        do_write(1'b0, 1'b1, 8'h7F); do_read(1'b0, 1'b0, d);
        check("R3 0x7F view", d, 8'h00);
        do_write(1'b0, 1'b1, 8'hC3); do_read(1'b0, 1'b0, d);
        check("R3 0xC3 view", d, 8'h86);
        do_write(1'b0, 1'b1, 8'h80); do_read(1'b0, 1'b0, d);
        check("R3 0x80 view", d, 8'h00);
    endtask

    task automatic t_ns_write_blocked();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'h40);
        do_write(1'b0, 1'b0, 8'hFF);
        do_read(1'b0, 1'b1, d);
        check("R4 blocked write", d, 8'h40);
    endtask

    task automatic t_ns_write_accept();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'h80);
        do_write(1'b0, 1'b0, 8'h64);
        do_read(1'b0, 1'b1, d);
        check("R5 stored form", d, 8'hB2);
        do_read(1'b0, 1'b0, d);
        check("R5 ns readback", d, 8'h64);
        do_write(1'b0, 1'b0, 8'h01);
        do_read(1'b0, 1'b1, d);
        check("R5 msb forced", d, 8'h80);
    endtask

    task automatic t_conditions();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'h20);
        top_el_present = 1'b0;
        do_read(1'b0, 1'b0, d);
        check("R6 no top level read", d, 8'h20);
        do_write(1'b0, 1'b0, 8'h11);
        do_read(1'b0, 1'b1, d);
        check("R6 no top level write", d, 8'h11);
        top_el_present = 1'b1; grp0_route_top = 1'b0;
        do_read(1'b0, 1'b0, d);
        check("R6 no routing read", d, 8'h11);
        do_write(1'b0, 1'b0, 8'h33);
        do_read(1'b0, 1'b1, d);
        check("R6 no routing write", d, 8'h33);
        grp0_route_top = 1'b1;
        do_read(1'b0, 1'b0, d);
        check("R6 all conditions", d, 8'h00);
    endtask

    task automatic t_running();
        logic [7:0] d;
        run_prio = 8'hFF; do_read(1'b1, 1'b0, d);
        check("R7 idle ns view", d, 8'hFE);
        run_prio = 8'h40; do_read(1'b1, 1'b0, d);
        check("R7 secure range ns view", d, 8'h00);
        do_read(1'b1, 1'b1, d);
        check("R7 secure view", d, 8'h40);
        run_prio = 8'hFF;
    endtask

    task automatic t_running_write();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'h77);
        do_write(1'b1, 1'b1, 8'h99);
        do_read(1'b0, 1'b1, d);
        check("R8 mask unchanged", d, 8'h77);
    endtask

    task automatic t_pass();
        do_write(1'b0, 1'b1, 8'h80);
        @(negedge clk); cand_prio = 8'h7F; #1;
        check("R9 below passes", int'(cand_pass), 1);
        cand_prio = 8'h80; #1;
        check("R9 equal blocked", int'(cand_pass), 0);
        cand_prio = 8'hFF; #1;
        check("R9 above blocked", int'(cand_pass), 0);
        do_write(1'b0, 1'b1, 8'hFF);
        @(negedge clk); cand_prio = 8'hFE; #1;
        check("R9 0xFE under 0xFF", int'(cand_pass), 1);
    endtask

    task automatic t_timing();
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = 1'b0; bus_secure = 1'b1;
        check("R10 no rvalid same cycle", int'(bus_rvalid), 0);
        @(negedge clk); bus_rd = 1'b0;
        check("R10 rvalid next cycle", int'(bus_rvalid), 1);
        @(negedge clk);
        check("R10 rvalid single", int'(bus_rvalid), 0);
    endtask

    task automatic t_rdwr();
        logic [7:0] d;
        do_write(1'b0, 1'b1, 8'h33);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_sel = 1'b0; bus_secure = 1'b1; bus_wdata = 8'h44;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R11 old value read", bus_rdata, 8'h33);
        do_read(1'b0, 1'b1, d);
        check("R11 new value stored", d, 8'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_direct();
        t_ns_read();
        t_ns_write_blocked();
        t_ns_write_accept();
        t_conditions();
        t_running();
        t_running_write();
        t_pass();
        t_timing();
        t_rdwr();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule